// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a multicycle datapath in which one ALU and one memory port are reused from cycle to cycle. It is a Moore machine. It takes the 6-bit opcode held in the instruction register and steps through a short run of states for each instruction. In every state it drives the write strobes and multiplexer selects that the datapath needs. It decodes five instruction kinds:

- register-to-register ALU operations
- word loads with register plus immediate addressing
- word stores
- branch-if-equal
- a second load form whose address is the sum of two registers (rs + rt) and whose result goes to rd.

States and transitions:

- `S_FETCH` always goes to `S_DECODE`.
- `S_DECODE` dispatches on the opcode:
  - ALU operation goes to `S_EXEC`.
  - Load or store goes to `S_MEM_ADDR`.
  - Branch goes to `S_BR_CMP`.
  - Register-indexed load goes to `S_RR_ADDR`.
  - Any other opcode goes back to `S_FETCH`.
- `S_MEM_ADDR` goes to `S_MEM_READ` for a load and to `S_MEM_STORE` for a store.
- `S_MEM_READ` goes to `S_MEM_WB`.
- `S_EXEC` goes to `S_ALU_WB`.
- `S_RR_ADDR` goes to `S_RR_READ`, which goes to `S_RR_WB`.
- `S_MEM_WB`, `S_MEM_STORE`, `S_ALU_WB`, `S_BR_CMP` and `S_RR_WB` all return to `S_FETCH`.
- A synchronous reset sends the machine to `S_FETCH` from any state.

Top module: `mcc_ctrl_fsm`

## Requirements
The control word is described below as a list of fields; every field not named for a state is 0. Opcodes: ALU operation 000000, load 100011, store 101011, branch 000100, register-indexed load 110011.

- R1: When `rst` is high at a rising clock edge, the outputs after that edge are the fetch-state word, whatever state the machine was in.
- R2: Fetch state drives the following and is always followed by decode:
  - `mem_rd`=1, `ir_wr`=1, `pc_wr`=1
  - `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00, `pc_src`=00
- R3: Decode state drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00 (branch target). Any opcode outside the five listed returns the machine to fetch, so that instruction takes 2 cycles.
- R4: An ALU operation takes 4 cycles: fetch, decode, execute, write-back.
  - Execute drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10.
  - Write-back drives `dst_sel`=1, `rf_wr`=1.
- R5: A load takes 5 cycles: fetch, decode, address, read, write-back.
  - Address drives `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00.
  - Read drives `mem_rd`=1, `addr_sel`=1.
  - Write-back drives `rf_wr`=1, `wb_from_mem`=1, `dst_sel`=0.
- R6: A store takes 4 cycles: fetch, decode, the same address state as R5, then a store state driving `mem_wr`=1 and `addr_sel`=1.
- R7: A branch takes 3 cycles: fetch, decode, then compare. Compare drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_wr_cond`=1, `pc_src`=01. `pc_wr` and `pc_wr_cond` are never both 1.
- R8: A register-indexed load takes 5 cycles: fetch, decode, then three states of its own.
  - Add state drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=00.
  - Read state drives `mem_rd`=1, `addr_sel`=1.
  - Write-back drives `dst_sel`=1, `rf_wr`=1, `wb_from_mem`=1.
  - The machine then returns to fetch.
- R9: Outputs depend on the current state only: changing `opcode` within a cycle leaves them unchanged. `mem_rd` and `mem_wr` are never both 1, and `rf_wr` is never 1 together with a memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU zero flag is set |
| pc_src | output | 2 | Program counter source select: 00 ALU result, 01 ALU output register |
| addr_sel | output | 1 | Memory address select: 0 program counter, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data: 0 ALU output, 1 memory data register |
| dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| rf_wr | output | 1 | Register file write strobe |
| alu_a_sel | output | 1 | ALU input A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 from function field |

## Verification
The checker watches several properties on every cycle:

- The read and write strobes are mutually exclusive.
- The two program counter writes are never both 1.
- Register writes never coincide with memory access.
- Every instruction load is followed by the decode word, and the first cycle after reset is a fetch.
- Any memory read at a computed address comes right after an add-mode address cycle.
- Any register write from memory comes right after such a read.

Only the bench's scenarios can show the following:

- Each opcode picks the right path and the right number of cycles; the bench sweeps all 64 opcodes and compares the full control word cycle by cycle.
- Outputs do not react to opcode changes within a state.
- A reset in the middle of an instruction aborts it back to fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    // Control states of the sequencer.
    typedef enum logic [3:0] {
        S_FETCH     = 4'd0,
        S_DECODE    = 4'd1,
        S_MEM_ADDR  = 4'd2,
        S_MEM_READ  = 4'd3,
        S_MEM_WB    = 4'd4,
        S_MEM_STORE = 4'd5,
        S_EXEC      = 4'd6,
        S_ALU_WB    = 4'd7,
        S_BR_CMP    = 4'd8,
        S_RR_ADDR   = 4'd9,
        S_RR_READ   = 4'd10,
        S_RR_WB     = 4'd11
    } state_e;

    // Instruction classes after opcode decoding.
    typedef enum logic [2:0] {
        IC_ALU   = 3'd0,
        IC_LOAD  = 3'd1,
        IC_STORE = 3'd2,
        IC_BEQ   = 3'd3,
        IC_RRLD  = 3'd4,
        IC_NONE  = 3'd5
    } iclass_e;

    // Select encodings.
    localparam logic [1:0] ASRC_B_REG   = 2'b00;
    localparam logic [1:0] ASRC_B_FOUR  = 2'b01;
    localparam logic [1:0] ASRC_B_IMM   = 2'b10;
    localparam logic [1:0] ASRC_B_SHIMM = 2'b11;

    localparam logic [1:0] AOP_ADD   = 2'b00;
    localparam logic [1:0] AOP_SUB   = 2'b01;
    localparam logic [1:0] AOP_FUNCT = 2'b10;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_AOUT = 2'b01;

    // Full control word for one cycle.
    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_from_mem;
        logic       dst_sel;
        logic       rf_wr;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcc_op_classify.sv
module mcc_op_classify
    import mcc_pkg::*;
#(
    parameter int          OP_W      = 6,
    parameter logic [5:0]  OPC_ALU   = 6'b000000,
    parameter logic [5:0]  OPC_LOAD  = 6'b100011,
    parameter logic [5:0]  OPC_STORE = 6'b101011,
    parameter logic [5:0]  OPC_BEQ   = 6'b000100,
    parameter logic [5:0]  OPC_RRLD  = 6'b110011
) (
    input  logic [OP_W-1:0] opcode,
    output iclass_e         iclass
);

    always_comb begin
        if (opcode == OPC_ALU)        iclass = IC_ALU;
        else if (opcode == OPC_LOAD)  iclass = IC_LOAD;
        else if (opcode == OPC_STORE) iclass = IC_STORE;
        else if (opcode == OPC_BEQ)   iclass = IC_BEQ;
        else if (opcode == OPC_RRLD)  iclass = IC_RRLD;
        else                          iclass = IC_NONE;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e  cur,
    input  iclass_e iclass,
    output state_e  nxt
);

    always_comb begin
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:     nxt = S_DECODE;
            S_DECODE: begin
                unique case (iclass)
                    IC_ALU:   nxt = S_EXEC;
                    IC_LOAD:  nxt = S_MEM_ADDR;
                    IC_STORE: nxt = S_MEM_ADDR;
                    IC_BEQ:   nxt = S_BR_CMP;
                    IC_RRLD:  nxt = S_RR_ADDR;
                    default:  nxt = S_FETCH;
                endcase
            end
            S_MEM_ADDR:  nxt = (iclass == IC_STORE) ? S_MEM_STORE : S_MEM_READ;
            S_MEM_READ:  nxt = S_MEM_WB;
            S_MEM_WB:    nxt = S_FETCH;
            S_MEM_STORE: nxt = S_FETCH;
            S_EXEC:      nxt = S_ALU_WB;
            S_ALU_WB:    nxt = S_FETCH;
            S_BR_CMP:    nxt = S_FETCH;
            S_RR_ADDR:   nxt = S_RR_READ;
            S_RR_READ:   nxt = S_RR_WB;
            S_RR_WB:     nxt = S_FETCH;
            default:     nxt = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (cur)
            S_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.addr_sel  = 1'b0;
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b_sel = ASRC_B_FOUR;
                ctrl.alu_op    = AOP_ADD;
                ctrl.pc_src    = PCS_ALU;
                ctrl.pc_wr     = 1'b1;
            end
            S_DECODE: begin
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b_sel = ASRC_B_SHIMM;
                ctrl.alu_op    = AOP_ADD;
            end
            S_MEM_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = ASRC_B_IMM;
                ctrl.alu_op    = AOP_ADD;
            end
            S_MEM_READ, S_RR_READ: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            S_MEM_WB: begin
                ctrl.rf_wr       = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.dst_sel     = 1'b0;
            end
            S_MEM_STORE: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            S_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = ASRC_B_REG;
                ctrl.alu_op    = AOP_FUNCT;
            end
            S_ALU_WB: begin
                ctrl.dst_sel = 1'b1;
                ctrl.rf_wr   = 1'b1;
            end
            S_BR_CMP: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = ASRC_B_REG;
                ctrl.alu_op     = AOP_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PCS_AOUT;
            end
            S_RR_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = ASRC_B_REG;
                ctrl.alu_op    = AOP_ADD;
            end
            S_RR_WB: begin
                ctrl.dst_sel     = 1'b1;
                ctrl.rf_wr       = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int         OP_W      = 6,
    parameter logic [5:0] OPC_ALU   = 6'b000000,
    parameter logic [5:0] OPC_LOAD  = 6'b100011,
    parameter logic [5:0] OPC_STORE = 6'b101011,
    parameter logic [5:0] OPC_BEQ   = 6'b000100,
    parameter logic [5:0] OPC_RRLD  = 6'b110011
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic [1:0]      pc_src,
    output logic            addr_sel,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            wb_from_mem,
    output logic            dst_sel,
    output logic            rf_wr,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op
);

    state_e  state_q;
    state_e  state_d;
    iclass_e iclass;
    ctrl_t   ctrl;

    mcc_op_classify #(
        .OP_W      (OP_W),
        .OPC_ALU   (OPC_ALU),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE),
        .OPC_BEQ   (OPC_BEQ),
        .OPC_RRLD  (OPC_RRLD)
    ) u_classify (
        .opcode (opcode),
        .iclass (iclass)
    );

    mcc_next_state u_next (
        .cur    (state_q),
        .iclass (iclass),
        .nxt    (state_d)
    );

    // State register, synchronous reset to fetch.
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_d;
    end

    mcc_ctrl_decode u_decode (
        .cur  (state_q),
        .ctrl (ctrl)
    );

    assign pc_wr       = ctrl.pc_wr;
    assign pc_wr_cond  = ctrl.pc_wr_cond;
    assign pc_src      = ctrl.pc_src;
    assign addr_sel    = ctrl.addr_sel;
    assign mem_rd      = ctrl.mem_rd;
    assign mem_wr      = ctrl.mem_wr;
    assign ir_wr       = ctrl.ir_wr;
    assign wb_from_mem = ctrl.wb_from_mem;
    assign dst_sel     = ctrl.dst_sel;
    assign rf_wr       = ctrl.rf_wr;
    assign alu_a_sel   = ctrl.alu_a_sel;
    assign alu_b_sel   = ctrl.alu_b_sel;
    assign alu_op      = ctrl.alu_op;

endmodule

// File: rtl/mcc_ctrl_fsm_chk.sv
module mcc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       addr_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       wb_from_mem,
    input logic       rf_wr,
    input logic       alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_op,
    input logic [3:0] state_q
);

    assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_wr && pc_wr && mem_rd && !addr_sel));

    assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && alu_b_sel == 2'b11 && !alu_a_sel));

    assert_single_pc_writer_R7: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond));

    assert_mem_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_rf_write_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> (!mem_rd && !mem_wr));

    assert_data_read_after_add_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |-> $past(alu_a_sel && alu_op == 2'b00 && !ir_wr));

    assert_mem_wb_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rf_wr && wb_from_mem) |-> $past(mem_rd && addr_sel));

    assert_state_legal_R3: assert property (@(posedge clk) disable iff (rst)
        state_q <= 4'd11);

endmodule

bind mcc_ctrl_fsm mcc_ctrl_fsm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_wr       (pc_wr),
    .pc_wr_cond  (pc_wr_cond),
    .addr_sel    (addr_sel),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .ir_wr       (ir_wr),
    .wb_from_mem (wb_from_mem),
    .rf_wr       (rf_wr),
    .alu_a_sel   (alu_a_sel),
    .alu_b_sel   (alu_b_sel),
    .alu_op      (alu_op),
    .state_q     (state_q)
);

// File: tb/mcc_ctrl_fsm_tb.sv
module mcc_ctrl_fsm_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       wb_from_mem, dst_sel, rf_wr, alu_a_sel;
    logic [1:0] pc_src, alu_b_sel, alu_op;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_ctrl_fsm u_dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
        .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_wr(ir_wr), .wb_from_mem(wb_from_mem), .dst_sel(dst_sel),
        .rf_wr(rf_wr), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op)
    );

    // Phase codes used by the bench only.
    localparam int P_F = 0, P_D = 1, P_MA = 2, P_MR = 3, P_MW = 4, P_MS = 5;
    localparam int P_EX = 6, P_RW = 7, P_BR = 8, P_RA = 9, P_RB = 10, P_RC = 11;

    function automatic logic [15:0] got_word();
        return {pc_wr, pc_wr_cond, pc_src, addr_sel, mem_rd, mem_wr, ir_wr,
                wb_from_mem, dst_sel, rf_wr, alu_a_sel, alu_b_sel, alu_op};
    endfunction

    // Build a word from named fields, everything else 0.
    function automatic logic [15:0] mk(bit pw, bit pwc, logic [1:0] ps, bit as,
                                       bit mr, bit mw, bit iw, bit wm, bit ds,
                                       bit rw, bit aa, logic [1:0] ab, logic [1:0] ao);
        return {pw, pwc, ps, as, mr, mw, iw, wm, ds, rw, aa, ab, ao};
    endfunction

    function automatic logic [15:0] exp_word(int ph);
        case (ph)
            P_F:  return mk(1,0,2'b00,0,1,0,1,0,0,0,0,2'b01,2'b00);
            P_D:  return mk(0,0,2'b00,0,0,0,0,0,0,0,0,2'b11,2'b00);
            P_MA: return mk(0,0,2'b00,0,0,0,0,0,0,0,1,2'b10,2'b00);
            P_MR: return mk(0,0,2'b00,1,1,0,0,0,0,0,0,2'b00,2'b00);
            P_MW: return mk(0,0,2'b00,0,0,0,0,1,0,1,0,2'b00,2'b00);
            P_MS: return mk(0,0,2'b00,1,0,1,0,0,0,0,0,2'b00,2'b00);
            P_EX: return mk(0,0,2'b00,0,0,0,0,0,0,0,1,2'b00,2'b10);
            P_RW: return mk(0,0,2'b00,0,0,0,0,0,1,1,0,2'b00,2'b00);
            P_BR: return mk(0,1,2'b01,0,0,0,0,0,0,0,1,2'b00,2'b01);
            P_RA: return mk(0,0,2'b00,0,0,0,0,0,0,0,1,2'b00,2'b00);
            P_RB: return mk(0,0,2'b00,1,1,0,0,0,0,0,0,2'b00,2'b00);
            default: return mk(0,0,2'b00,0,0,0,0,1,1,1,0,2'b00,2'b00);
        endcase
    endfunction

    function automatic string req_of(int ph, logic [5:0] op);
        case (ph)
            P_F: return "R2";
            P_D: return "R3";
            P_MA: return (op == 6'b101011) ? "R6" : "R5";
            P_MR, P_MW: return "R5";
            P_MS: return "R6";
            P_EX, P_RW: return "R4";
            P_BR: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int seq_len(logic [5:0] op);
        case (op)
            6'b000000: return 4;
            6'b100011: return 5;
            6'b101011: return 4;
            6'b000100: return 3;
            6'b110011: return 5;
            default:   return 2;
        endcase
    endfunction

    function automatic int seq_phase(logic [5:0] op, int i);
        if (i == 0) return P_F;
        if (i == 1) return P_D;
        case (op)
            6'b000000: return (i == 2) ? P_EX : P_RW;
            6'b100011: return (i == 2) ? P_MA : (i == 3) ? P_MR : P_MW;
            6'b101011: return (i == 2) ? P_MA : P_MS;
            6'b000100: return P_BR;
            default:   return (i == 2) ? P_RA : (i == 3) ? P_RB : P_RC;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] exp);
        logic [15:0] got = got_word();
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
        end
    endtask

    // Run one instruction starting in fetch; leaves the bench at the next fetch.
    task automatic run_op(logic [5:0] op);
        opcode = op;
        for (int i = 0; i < seq_len(op); i++) begin
            int ph = seq_phase(op, i);
            check(req_of(ph, op), exp_word(ph));
            if (i < 2) begin
                // R9: outputs must not follow a changing opcode within a state
                opcode = ~op;
                #1;
                check("R9", exp_word(ph));
                opcode = op;
                #1;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", exp_word(P_F));         // R1 reset state
        rst = 1'b0;

        // Exhaustive opcode sweep.
        for (int k = 0; k < 64; k++) run_op(6'(k));

        // Back-to-back mix of the defined opcodes.
        run_op(6'b110011);
        run_op(6'b101011);
        run_op(6'b000100);
        run_op(6'b100011);
        run_op(6'b000000);
        run_op(6'b110011);

        // R1: reset in the middle of a register-indexed load (in add state).
        opcode = 6'b110011;
        @(negedge clk);                     // decode
        @(negedge clk);                     // add state
        check("R8", exp_word(P_RA));
        rst = 1'b1;
        @(negedge clk);
        check("R1", exp_word(P_F));
        rst = 1'b0;
        run_op(6'b100011);

        // R1: reset while in store state.
        opcode = 6'b101011;
        repeat (3) @(negedge clk);
        check("R6", exp_word(P_MS));
        rst = 1'b1;
        @(negedge clk);
        check("R1", exp_word(P_F));
        rst = 1'b0;
        run_op(6'b000100);

        finish_run();
    end

endmodule